// File: doc/BRIEF.md
# Multicast hash address filter

This block decides whether an incoming Ethernet frame should be kept, judging only its 48-bit destination address. The address arrives one byte per clock, first byte first. A start strobe marks the first byte. One clock after the sixth byte, the block reports an accept or reject verdict together with a one-cycle valid flag.

The verdict depends on the kind of address:
- **Unicast** (group bit clear): accepted only when it equals the programmed station address.
- **Group**: folded through a bit-reflected CRC-32. Six bits of the CRC index a 64-bit hash table held as four 16-bit words, and the indexed bit decides.
- **Broadcast** (all ones): always kept.
- **Mode word**: can force acceptance of every group address, or of every frame.

Configuration is written through a small word-wide write port.

The register map is as follows:

| Address | Contents |
|---|---|
| 0 | Mode word |
| 1 to 3 | Station address words 0 to 2 |
| 4 to 7 | Hash table words 0 to 3 |
| 8 to 15 | Unused |

Configuration written before the sixth byte of an address is used for that address's verdict.

Top module: `mac_hash_filter`

## Requirements
- R1: While reset is asserted and until the first address completes, dec_valid and dec_accept are 0.
- R2: in_vld with in_sof presents byte 0. Later cycles with in_vld present bytes 1 to 5, and idle cycles between bytes are allowed. dec_valid is high for exactly the one cycle after the sixth byte, and dec_accept holds its value until the next verdict.
- R3: For a group address, the CRC register is preset to 0xFFFFFFFF. Each byte is shifted in LSB first with the reflected polynomial 0xEDB88320, and the result is not inverted. The index is CRC bits 31:26. Index bits 5:4 pick the hash word (config address 4 plus that value), and index bits 3:0 pick the bit within that word. The address is accepted exactly when that bit is 1.
- R4: Mode bit 14 set accepts every group address whatever the hash table holds. Unicast handling is unchanged.
- R5: Mode bit 15 set accepts every address.
- R6: An address whose byte 0 bit 0 is 0 is accepted only when all six bytes equal the station address. Station word k (config address 1+k) holds byte 2k in bits 7:0 and byte 2k+1 in bits 15:8. The hash table has no effect on such addresses.
- R7: FF:FF:FF:FF:FF:FF is accepted with an empty table and mode 0. A group address differing from it in one byte goes through the hash.
- R8: in_sof during an incomplete address discards the bytes taken so far and restarts at byte 0. Only one verdict results.
- R9: in_vld without in_sof, while no address is in progress, produces no verdict and does not alter the verdict of the next address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration word address |
| cfg_wdata | input | 16 | Configuration write data |
| in_vld | input | 1 | Address byte valid |
| in_sof | input | 1 | Marks byte 0 of an address (with in_vld) |
| in_byte | input | 8 | Address byte |
| dec_valid | output | 1 | Verdict valid, one-cycle pulse |
| dec_accept | output | 1 | Verdict: 1 keep, 0 drop |

## Verification
Each kind of wrong internal state shows up at the ports within one address, one clock after the sixth byte:
- **Wrong CRC state:** a group address whose single table bit is set comes out rejected. Its neighbour word with the same bit set comes out accepted.
- **Corrupted byte counter:** dec_valid pulses early, late or not at all, so every test pins the exact cycle of the pulse. Gapped, restarted and stray byte streams stress this counter.
- **Stuck compare flag:** a unicast address differing only in its first or last byte is accepted.

// File: rtl/mhf_pkg.sv
package mhf_pkg;

  localparam int          CRC_W        = 32;
  localparam logic [31:0] CRC_POLY_REF = 32'hEDB88320;

  // Configuration word map: 0 mode, then station words, then hash words.
  localparam int CFG_MODE_ADDR = 0;
  localparam int CFG_STA_BASE  = 1;

  // One byte through a bit-reflected CRC register, LSB of the byte first.
  function automatic logic [CRC_W-1:0] crc_ref_byte(
    input logic [CRC_W-1:0] crc_in,
    input logic [7:0]       data,
    input logic [CRC_W-1:0] poly
  );
    logic [CRC_W-1:0] c;
    c = crc_in;
    for (int i = 0; i < 8; i++) begin
      if (c[0] ^ data[i]) c = (c >> 1) ^ poly;
      else                c = c >> 1;
    end
    return c;
  endfunction

endpackage

// File: rtl/mhf_cfg_regs.sv
module mhf_cfg_regs #(
  parameter int WORD_W     = 16,
  parameter int STA_WORDS  = 3,
  parameter int HASH_WORDS = 4,
  parameter int CFG_AW     = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cfg_we,
  input  logic [CFG_AW-1:0]            cfg_addr,
  input  logic [WORD_W-1:0]            cfg_wdata,
  output logic                         mode_promisc,
  output logic                         mode_allgrp,
  output logic [STA_WORDS*WORD_W-1:0]  sta_flat,
  output logic [HASH_WORDS*WORD_W-1:0] hash_flat
);
  import mhf_pkg::*;

  localparam int HASH_BASE = CFG_STA_BASE + STA_WORDS;

  // Mode word: only the two top bits are kept.
  logic mode_en;
  logic prom_q, prom_d;
  logic allg_q, allg_d;

  assign mode_en = cfg_we && (cfg_addr == CFG_AW'(CFG_MODE_ADDR));

  always_comb begin
    prom_d = prom_q;
    allg_d = allg_q;
    if (mode_en) begin
      prom_d = cfg_wdata[WORD_W-1];
      allg_d = cfg_wdata[WORD_W-2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prom_q <= 1'b0;
      allg_q <= 1'b0;
    end else begin
      prom_q <= prom_d;
      allg_q <= allg_d;
    end
  end

  assign mode_promisc = prom_q;
  assign mode_allgrp  = allg_q;

  // Station address words.
  for (genvar k = 0; k < STA_WORDS; k++) begin : g_sta
    logic              en;
    logic [WORD_W-1:0] q, d;
    assign en = cfg_we && (cfg_addr == CFG_AW'(CFG_STA_BASE + k));
    always_comb d = en ? cfg_wdata : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign sta_flat[k*WORD_W +: WORD_W] = q;
  end

  // Hash table words.
  for (genvar k = 0; k < HASH_WORDS; k++) begin : g_hash
    logic              en;
    logic [WORD_W-1:0] q, d;
    assign en = cfg_we && (cfg_addr == CFG_AW'(HASH_BASE + k));
    always_comb d = en ? cfg_wdata : q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
    assign hash_flat[k*WORD_W +: WORD_W] = q;
  end

  // R5/R4: a mode write lands in the next cycle.
  a_r5_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
    mode_en |=> (mode_promisc == $past(cfg_wdata[WORD_W-1])) &&
                (mode_allgrp  == $past(cfg_wdata[WORD_W-2])));

endmodule

// File: rtl/mhf_crc_engine.sv
module mhf_crc_engine #(
  parameter logic [31:0] CRC_POLY = 32'hEDB88320,
  parameter int          IDX_W    = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             restart,
  input  logic [7:0]       data,
  output logic [IDX_W-1:0] idx_next
);
  import mhf_pkg::*;

  logic [CRC_W-1:0] crc_q, crc_d, crc_base, crc_step;

  // A new address starts from all ones; otherwise continue the running value.
  assign crc_base = restart ? '1 : crc_q;
  assign crc_step = crc_ref_byte(crc_base, data, CRC_POLY);

  always_comb begin
    crc_d = crc_q;
    if (take) crc_d = crc_step;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

  // Index from the top bits, no final inversion.
  assign idx_next = crc_step[CRC_W-1 -: IDX_W];

  // R3: the running CRC only moves on accepted bytes.
  a_r3_crc_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !take |=> $stable(crc_q));

endmodule

// File: rtl/mhf_addr_track.sv
module mhf_addr_track #(
  parameter int ADDR_BYTES = 6,
  parameter int CNT_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic                    in_sof,
  input  logic [7:0]              in_byte,
  input  logic [ADDR_BYTES*8-1:0] sta_flat,
  output logic                    take,
  output logic                    last,
  output logic                    ucast_hit,
  output logic                    bcast_hit,
  output logic                    group_addr
);

  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             uc_q, uc_d;
  logic             bc_q, bc_d;
  logic             grp_q, grp_d;
  logic [CNT_W-1:0] pos;
  logic             first;
  logic [7:0]       sta_b [ADDR_BYTES];
  logic             uc_n, bc_n, grp_n;

  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_sta_byte
    assign sta_b[k] = sta_flat[k*8 +: 8];
  end

  // A start strobe always forces byte 0.
  assign pos   = in_sof ? '0 : cnt_q;
  assign first = (pos == '0);
  assign take  = in_vld && (in_sof || busy_q);
  assign last  = take && (pos == CNT_W'(ADDR_BYTES-1));

  // Running compares, seeded on byte 0.
  assign uc_n  = (first ? 1'b1 : uc_q) & (in_byte == sta_b[pos]);
  assign bc_n  = (first ? 1'b1 : bc_q) & (&in_byte);
  assign grp_n = first ? in_byte[0] : grp_q;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    uc_d   = uc_q;
    bc_d   = bc_q;
    grp_d  = grp_q;
    if (take) begin
      busy_d = !last;
      cnt_d  = last ? '0 : pos + 1'b1;
      uc_d   = uc_n;
      bc_d   = bc_n;
      grp_d  = grp_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      uc_q   <= 1'b0;
      bc_q   <= 1'b0;
      grp_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      uc_q   <= uc_d;
      bc_q   <= bc_d;
      grp_q  <= grp_d;
    end
  end

  assign ucast_hit  = uc_n;
  assign bcast_hit  = bc_n;
  assign group_addr = grp_n;

  // R2: byte position never leaves the address.
  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(ADDR_BYTES));

  // R9: when idle the counter rests at zero.
  a_r9_idle_cnt: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> (cnt_q == '0));

  // R9: a stray byte with no address open cannot finish one.
  a_r9_no_stray_last: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && !in_sof) |-> !last);

endmodule

// File: rtl/mac_hash_filter.sv
module mac_hash_filter #(
  parameter int          ADDR_BYTES = 6,
  parameter int          WORD_W     = 16,
  parameter int          HASH_WORDS = 4,
  parameter int          CFG_AW     = 4,
  parameter logic [31:0] CRC_POLY   = 32'hEDB88320
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [WORD_W-1:0] cfg_wdata,
  input  logic              in_vld,
  input  logic              in_sof,
  input  logic [7:0]        in_byte,
  output logic              dec_valid,
  output logic              dec_accept
);

  localparam int HASH_BITS = WORD_W * HASH_WORDS;
  localparam int IDX_W     = $clog2(HASH_BITS);
  localparam int STA_WORDS = (ADDR_BYTES * 8) / WORD_W;
  localparam int CNT_W     = $clog2(ADDR_BYTES);

  // Reset: asserted at once, released two clocks later.
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end

  assign rst_int_n = rst_sync_q[1];

  logic                         mode_promisc, mode_allgrp;
  logic [STA_WORDS*WORD_W-1:0]  sta_flat;
  logic [HASH_WORDS*WORD_W-1:0] hash_flat;
  logic                         take, last;
  logic                         ucast_hit, bcast_hit, group_addr;
  logic [IDX_W-1:0]             idx_next;

  mhf_cfg_regs #(
    .WORD_W    (WORD_W),
    .STA_WORDS (STA_WORDS),
    .HASH_WORDS(HASH_WORDS),
    .CFG_AW    (CFG_AW)
  ) u_cfg (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .cfg_we      (cfg_we),
    .cfg_addr    (cfg_addr),
    .cfg_wdata   (cfg_wdata),
    .mode_promisc(mode_promisc),
    .mode_allgrp (mode_allgrp),
    .sta_flat    (sta_flat),
    .hash_flat   (hash_flat)
  );

  mhf_addr_track #(
    .ADDR_BYTES(ADDR_BYTES),
    .CNT_W     (CNT_W)
  ) u_track (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .in_vld    (in_vld),
    .in_sof    (in_sof),
    .in_byte   (in_byte),
    .sta_flat  (sta_flat),
    .take      (take),
    .last      (last),
    .ucast_hit (ucast_hit),
    .bcast_hit (bcast_hit),
    .group_addr(group_addr)
  );

  mhf_crc_engine #(
    .CRC_POLY(CRC_POLY),
    .IDX_W   (IDX_W)
  ) u_crc (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .take    (take),
    .restart (in_sof),
    .data    (in_byte),
    .idx_next(idx_next)
  );

  // Word w bit b of the table sits at flat position w*WORD_W+b, which is the
  // index itself: upper bits choose the word, lower bits the bit.
  logic hash_hit;
  logic verdict;

  assign hash_hit = hash_flat[idx_next];

  always_comb begin
    if (mode_promisc || bcast_hit) verdict = 1'b1;
    else if (group_addr)           verdict = mode_allgrp || hash_hit;
    else                           verdict = ucast_hit;
  end

  logic vld_q, vld_d;
  logic acc_q, acc_d;

  always_comb begin
    vld_d = last;
    acc_d = acc_q;
    if (last) acc_d = verdict;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q <= 1'b0;
      acc_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
      acc_q <= acc_d;
    end
  end

  assign dec_valid  = vld_q;
  assign dec_accept = acc_q;

  // R2: one pulse per address.
  if (ADDR_BYTES > 1) begin : g_pulse_chk
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_int_n)
      dec_valid |=> !dec_valid);
  end

  // R2: verdict is held between addresses.
  a_r2_acc_hold: assert property (@(posedge clk) disable iff (!rst_int_n)
    !last |=> $stable(dec_accept));

  // R5: promiscuous mode keeps everything.
  a_r5_promisc: assert property (@(posedge clk) disable iff (!rst_int_n)
    (last && mode_promisc) |=> (dec_valid && dec_accept));

  // R7: broadcast always kept.
  a_r7_bcast: assert property (@(posedge clk) disable iff (!rst_int_n)
    (last && bcast_hit) |=> dec_accept);

  // R6: unicast mismatch dropped unless promiscuous.
  a_r6_ucast_miss: assert property (@(posedge clk) disable iff (!rst_int_n)
    (last && !group_addr && !ucast_hit && !mode_promisc) |=> !dec_accept);

endmodule

// File: tb/sim_mac_hash_filter.sv
module sim_mac_hash_filter;

  logic        clk;
  logic        rst_n;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [15:0] cfg_wdata;
  logic        in_vld;
  logic        in_sof;
  logic [7:0]  in_byte;
  logic        dec_valid;
  logic        dec_accept;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  mac_hash_filter u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .in_vld    (in_vld),
    .in_sof    (in_sof),
    .in_byte   (in_byte),
    .dec_valid (dec_valid),
    .dec_accept(dec_accept)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Reference index: reflected CRC-32, preset ones, LSB first, no inversion.
  function automatic logic [5:0] ref_idx(input logic [47:0] a);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb;
      fb = c[0] ^ a[i];
      c  = {1'b0, c[31:1]};
      if (fb) c = c ^ 32'hEDB88320;
    end
    return c[31:26];
  endfunction

  task automatic cfg_write(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we    = 1'b1;
    cfg_addr  = a;
    cfg_wdata = d;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic clear_table();
    for (int w = 0; w < 4; w++) cfg_write(4'(4 + w), 16'h0000);
  endtask

  // Byte k of the address is a[8k+:8]; byte 0 goes first.
  task automatic send_check(input logic [47:0] a, input int gap, input bit exp, input string tag);
    for (int k = 0; k < 6; k++) begin
      if (k > 0) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          in_vld = 1'b0;
          in_sof = 1'b0;
          chk(dec_valid == 1'b0, {tag, " R2 no early valid"}, dec_valid, 0);
        end
      end
      @(negedge clk);
      chk(dec_valid == 1'b0, {tag, " R2 no early valid"}, dec_valid, 0);
      in_vld  = 1'b1;
      in_sof  = (k == 0);
      in_byte = a[8*k +: 8];
    end
    @(negedge clk);
    in_vld = 1'b0;
    in_sof = 1'b0;
    chk(dec_valid == 1'b1, {tag, " R2 valid after sixth byte"}, dec_valid, 1);
    chk(dec_accept == exp, tag, dec_accept, exp);
    @(negedge clk);
    chk(dec_valid == 1'b0, {tag, " R2 single pulse"}, dec_valid, 0);
    chk(dec_accept == exp, {tag, " R2 verdict held"}, dec_accept, exp);
  endtask

  task automatic send_partial(input logic [47:0] a, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      chk(dec_valid == 1'b0, "R8 no valid on partial", dec_valid, 0);
      in_vld  = 1'b1;
      in_sof  = (k == 0);
      in_byte = a[8*k +: 8];
    end
  endtask

  localparam logic [47:0] STA    = 48'h55_44_33_22_11_02;
  localparam logic [47:0] STA_X5 = 48'h56_44_33_22_11_02;
  localparam logic [47:0] STA_X0 = 48'h55_44_33_22_11_06;
  localparam logic [47:0] MC0    = 48'h01_00_00_5E_00_01;
  localparam logic [47:0] BCAST  = 48'hFF_FF_FF_FF_FF_FF;
  localparam logic [47:0] NEARBC = 48'hFE_FF_FF_FF_FF_FF;

  task automatic t_reset();
    chk(dec_valid == 1'b0, "R1 reset valid", dec_valid, 0);
    chk(dec_accept == 1'b0, "R1 reset accept", dec_accept, 0);
  endtask

  task automatic t_unicast();
    cfg_write(4'd1, 16'h1102);
    cfg_write(4'd2, 16'h3322);
    cfg_write(4'd3, 16'h5544);
    send_check(STA,    0, 1'b1, "R6 station match");
    send_check(STA_X5, 0, 1'b0, "R6 last byte differs");
    send_check(STA_X0, 0, 1'b0, "R6 first byte differs");
    for (int w = 0; w < 4; w++) cfg_write(4'(4 + w), 16'hFFFF);
    send_check(STA_X5, 0, 1'b0, "R6 full table no effect on unicast");
    clear_table();
  endtask

  task automatic t_hash();
    logic [47:0] mcs [3];
    mcs[0] = MC0;
    mcs[1] = 48'h01_00_00_00_33_33;
    mcs[2] = 48'h45_23_01_EF_CD_AB;
    for (int m = 0; m < 3; m++) begin
      logic [5:0] ix;
      ix = ref_idx(mcs[m]);
      clear_table();
      cfg_write(4'(4 + ix[5:4]), 16'h0001 << ix[3:0]);
      send_check(mcs[m], 0, 1'b1, "R3 single indexed bit accepts");
      for (int w = 0; w < 4; w++)
        cfg_write(4'(4 + w), (w == int'(ix[5:4])) ? ~(16'h0001 << ix[3:0]) : 16'hFFFF);
      send_check(mcs[m], 0, 1'b0, "R3 all but indexed bit rejects");
      clear_table();
      cfg_write(4'(4 + (ix[5:4] ^ 2'b01)), 16'h0001 << ix[3:0]);
      send_check(mcs[m], 0, 1'b0, "R3 same bit in wrong word rejects");
    end
    clear_table();
    for (int w = 0; w < 4; w++) cfg_write(4'(4 + w), 16'hFFFF);
    send_check(MC0, 0, 1'b1, "R3 full table accepts group");
    clear_table();
  endtask

  task automatic t_allgrp();
    cfg_write(4'd0, 16'h4000);
    send_check(MC0,    0, 1'b1, "R4 all-group mode accepts group");
    send_check(STA_X5, 0, 1'b0, "R4 all-group mode keeps unicast filter");
    send_check(STA,    0, 1'b1, "R4 all-group mode station still kept");
    cfg_write(4'd0, 16'h0000);
    send_check(MC0,    0, 1'b0, "R4 mode cleared, empty table rejects");
  endtask

  task automatic t_promisc();
    cfg_write(4'd0, 16'h8000);
    send_check(STA_X5, 0, 1'b1, "R5 promiscuous accepts unicast miss");
    send_check(MC0,    0, 1'b1, "R5 promiscuous accepts group, empty table");
    cfg_write(4'd0, 16'h0000);
    send_check(STA_X5, 0, 1'b0, "R5 promiscuous cleared");
  endtask

  task automatic t_bcast();
    send_check(BCAST,  0, 1'b1, "R7 broadcast accepted");
    send_check(NEARBC, 0, 1'b0, "R7 near-broadcast uses hash");
  endtask

  task automatic t_gaps();
    send_check(STA,    2, 1'b1, "R2 gapped station address");
    send_check(STA_X0, 1, 1'b0, "R2 gapped mismatch");
    send_check(BCAST,  3, 1'b1, "R2 gapped broadcast");
  endtask

  task automatic t_restart();
    send_partial(STA_X5, 3);
    send_check(STA,   0, 1'b1, "R8 restart to station");
    send_partial(STA, 5);
    send_check(STA_X0, 0, 1'b0, "R8 restart to mismatch");
  endtask

  task automatic t_stray();
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(dec_valid == 1'b0, "R9 stray byte no valid", dec_valid, 0);
      in_vld  = 1'b1;
      in_sof  = 1'b0;
      in_byte = STA[8*k +: 8];
    end
    @(negedge clk);
    in_vld = 1'b0;
    chk(dec_valid == 1'b0, "R9 no verdict from stray bytes", dec_valid, 0);
    chk(dec_accept == 1'b0, "R9 verdict unchanged", dec_accept, 0);
    @(negedge clk);
    chk(dec_valid == 1'b0, "R9 still no verdict", dec_valid, 0);
    send_check(STA_X5, 0, 1'b0, "R9 next address unaffected");
  endtask

  initial begin
    rst_n     = 1'b0;
    cfg_we    = 1'b0;
    cfg_addr  = '0;
    cfg_wdata = '0;
    in_vld    = 1'b0;
    in_sof    = 1'b0;
    in_byte   = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_unicast();
    t_hash();
    t_allgrp();
    t_promisc();
    t_bcast();
    t_gaps();
    t_restart();
    t_stray();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL R2 watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule